// File: doc/BRIEF.md
# Five-State Snooping Coherence Controller

This block keeps the coherence state of every line of a small cache under a five-state write-back protocol: Invalid, Shared, Exclusive, Owned and Modified. Owned lets a dirty line be handed to other caches without a memory write first. The block takes one processor request and one snooped bus request per cycle. It updates the state of the addressed lines and reports what the cache must do on the bus. It can issue a read, a read-exclusive or an upgrade, supply a line to another cache, or write a dirty victim back to memory.

The data arrays, the memory and the interconnect are outside the block. A read miss completes in the cycle it is presented. The bus tells the block, through a sharing input, whether another cache kept a copy. A debug-style query port returns the state of any one line and whether memory is stale for it.

Top module: `moesi_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, every line reads Invalid (state code 0) and no command, supply or write-back strobe is raised.
- R2: A load (processor op code 1) to an Invalid line raises bus command read (code 1) and leaves the line Exclusive (code 2) when the sharing input is 0, or Shared (code 1) when it is 1. A load that hits leaves the state unchanged and raises no command.
- R3: A store (op code 2) always leaves the line Modified (code 4). It raises read-exclusive (code 2) from Invalid and upgrade (code 3) from Shared or Owned (code 3). It raises no command from Exclusive or Modified.
- R4: A snooped read (snoop code 1) to a Modified or Owned line raises the supply strobe and leaves the line Owned. It does not raise the write-back strobe.
- R5: A snooped read to an Exclusive line leaves it Shared. A snooped read to a Shared or Invalid line leaves the state unchanged. None of these raises the supply strobe.
- R6: A snooped read-exclusive (code 2) or upgrade (code 3) leaves the line Invalid from any state. The supply strobe is raised exactly when the line was Modified or Owned.
- R7: An eviction (op code 3) leaves the line Invalid and raises no bus command. It raises the write-back strobe exactly when the line was Modified or Owned.
- R8: The stale output is 1 exactly when the queried line is Modified or Owned.
- R9: When the snoop and the processor request address the same line in one cycle, the snoop acts first. The processor request is then resolved against the state the snoop leaves.
- R10: Each command, supply and write-back strobe is registered. It is high for one cycle, in the cycle after the request, and carries the index of the line concerned.
- R11: A request to one line leaves the state of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op | input | 2 | Processor op: 0 idle, 1 load, 2 store, 3 evict |
| cpu_line | input | IDXW | Line addressed by the processor |
| fill_shared | input | 1 | Another cache holds the line on a load miss |
| snp_op | input | 2 | Snoop op: 0 idle, 1 read, 2 read-exclusive, 3 upgrade |
| snp_line | input | IDXW | Line addressed by the snoop |
| peek_line | input | IDXW | Line whose state is reported |
| peek_state | output | 3 | State of the queried line: 0 I, 1 S, 2 E, 3 O, 4 M |
| peek_stale | output | 1 | Memory is stale for the queried line |
| bus_cmd | output | 2 | Bus command: 0 none, 1 read, 2 read-exclusive, 3 upgrade |
| bus_cmd_line | output | IDXW | Line of the bus command |
| supply_strobe | output | 1 | Supply the line to another cache |
| supply_line | output | IDXW | Line to supply |
| wb_strobe | output | 1 | Write the victim line back to memory |
| wb_line | output | IDXW | Line to write back |

## Verification
The bench builds each of the five states on a line and applies every processor op and every snoop op to it. A design that wrote dirty data back on a snooped read, or supplied data from a clean line, would show a wrong strobe. A design that failed to leave Modified for Owned would show a wrong state. It then sweeps all same-cycle collisions of a snoop and a processor request on one line. A design that resolved the processor request against the pre-snoop state would issue the wrong command, for example no upgrade after a snooped read hits a Modified line. A neighbouring line is held Modified throughout, so stray enables on the wrong index show up.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        CPU_IDLE  = 2'd0,
        CPU_LOAD  = 2'd1,
        CPU_STORE = 2'd2,
        CPU_EVICT = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        SNP_IDLE    = 2'd0,
        SNP_READ    = 2'd1,
        SNP_READX   = 2'd2,
        SNP_UPGRADE = 2'd3
    } snp_op_e;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_READ    = 2'd1,
        CMD_READX   = 2'd2,
        CMD_UPGRADE = 2'd3
    } bus_cmd_e;

    typedef struct packed {
        line_state_e nxt;
        logic        supply;
    } snp_res_t;

    typedef struct packed {
        line_state_e nxt;
        bus_cmd_e    cmd;
        logic        wb;
    } cpu_res_t;

    // Memory copy is out of date for this line
    function automatic logic holds_dirty(line_state_e st);
        return (st == ST_M) || (st == ST_O);
    endfunction

    function automatic snp_res_t snoop_step(line_state_e cur, snp_op_e op);
        snp_res_t r;
        r.nxt    = cur;
        r.supply = 1'b0;
        case (op)
            SNP_READ: begin
                r.supply = holds_dirty(cur);
                case (cur)
                    ST_M:    r.nxt = ST_O;
                    ST_E:    r.nxt = ST_S;
                    default: r.nxt = cur;
                endcase
            end
            SNP_READX, SNP_UPGRADE: begin
                r.supply = holds_dirty(cur);
                r.nxt    = ST_I;
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic cpu_res_t cpu_step(line_state_e cur, cpu_op_e op, logic shared);
        cpu_res_t r;
        r.nxt = cur;
        r.cmd = CMD_NONE;
        r.wb  = 1'b0;
        case (op)
            CPU_LOAD: begin
                if (cur == ST_I) begin
                    r.cmd = CMD_READ;
                    r.nxt = shared ? ST_S : ST_E;
                end
            end
            CPU_STORE: begin
                r.nxt = ST_M;
                case (cur)
                    ST_I:       r.cmd = CMD_READX;
                    ST_S, ST_O: r.cmd = CMD_UPGRADE;
                    default:    r.cmd = CMD_NONE;
                endcase
            end
            CPU_EVICT: begin
                r.wb  = holds_dirty(cur);
                r.nxt = ST_I;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
    import moesi_pkg::*;
(
    input  line_state_e cur_i,
    input  snp_op_e     op_i,
    output snp_res_t    res_o
);
    always_comb begin
        res_o = snoop_step(cur_i, op_i);
    end
endmodule

// File: rtl/moesi_cpu_unit.sv
module moesi_cpu_unit
    import moesi_pkg::*;
(
    input  line_state_e cur_i,
    input  cpu_op_e     op_i,
    input  logic        shared_i,
    output cpu_res_t    res_o
);
    always_comb begin
        res_o = cpu_step(cur_i, op_i, shared_i);
    end
endmodule

// File: rtl/moesi_line_store.sv
module moesi_line_store
    import moesi_pkg::*;
#(
    parameter  int LINES = 4,
    localparam int IDXW  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     snp_en,
    input  logic [IDXW-1:0]          snp_line,
    input  line_state_e              snp_nxt,
    input  logic                     cpu_en,
    input  logic [IDXW-1:0]          cpu_line,
    input  line_state_e              cpu_nxt,
    output line_state_e [LINES-1:0]  st_o
);
    // The processor result already folds in a same-line snoop, so it wins.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (rst) begin
                st_o[i] <= ST_I;
            end else if (cpu_en && (cpu_line == IDXW'(i))) begin
                st_o[i] <= cpu_nxt;
            end else if (snp_en && (snp_line == IDXW'(i))) begin
                st_o[i] <= snp_nxt;
            end
        end
    end
endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
    import moesi_pkg::*;
#(
    parameter  int LINES = 4,
    localparam int IDXW  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      cpu_op,
    input  logic [IDXW-1:0] cpu_line,
    input  logic            fill_shared,
    input  logic [1:0]      snp_op,
    input  logic [IDXW-1:0] snp_line,
    input  logic [IDXW-1:0] peek_line,
    output logic [2:0]      peek_state,
    output logic            peek_stale,
    output logic [1:0]      bus_cmd,
    output logic [IDXW-1:0] bus_cmd_line,
    output logic            supply_strobe,
    output logic [IDXW-1:0] supply_line,
    output logic            wb_strobe,
    output logic [IDXW-1:0] wb_line
);
    line_state_e [LINES-1:0] line_st_q;

    cpu_op_e     cpu_k;
    snp_op_e     snp_k;
    logic        cpu_en;
    logic        snp_en;
    logic        collide;
    line_state_e snp_cur;
    line_state_e cpu_cur;
    snp_res_t    snp_res;
    cpu_res_t    cpu_res;

    assign cpu_k   = cpu_op_e'(cpu_op);
    assign snp_k   = snp_op_e'(snp_op);
    assign cpu_en  = (cpu_k != CPU_IDLE);
    assign snp_en  = (snp_k != SNP_IDLE);
    assign collide = cpu_en && snp_en && (cpu_line == snp_line);

    assign snp_cur = line_st_q[snp_line];

    moesi_snoop_unit u_snp (
        .cur_i (snp_cur),
        .op_i  (snp_k),
        .res_o (snp_res)
    );

    // Snoop is ordered first on the bus; processor sees its outcome.
    assign cpu_cur = collide ? snp_res.nxt : line_st_q[cpu_line];

    moesi_cpu_unit u_cpu (
        .cur_i    (cpu_cur),
        .op_i     (cpu_k),
        .shared_i (fill_shared),
        .res_o    (cpu_res)
    );

    moesi_line_store #(.LINES(LINES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .snp_en   (snp_en),
        .snp_line (snp_line),
        .snp_nxt  (snp_res.nxt),
        .cpu_en   (cpu_en),
        .cpu_line (cpu_line),
        .cpu_nxt  (cpu_res.nxt),
        .st_o     (line_st_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_cmd       <= CMD_NONE;
            bus_cmd_line  <= '0;
            supply_strobe <= 1'b0;
            supply_line   <= '0;
            wb_strobe     <= 1'b0;
            wb_line       <= '0;
        end else begin
            bus_cmd       <= cpu_res.cmd;
            bus_cmd_line  <= cpu_line;
            supply_strobe <= snp_en && snp_res.supply;
            supply_line   <= snp_line;
            wb_strobe     <= cpu_en && cpu_res.wb;
            wb_line       <= cpu_line;
        end
    end

    assign peek_state = line_st_q[peek_line];
    assign peek_stale = holds_dirty(line_st_q[peek_line]);

endmodule

// File: rtl/moesi_ctrl_chk.sv
module moesi_ctrl_chk
    import moesi_pkg::*;
#(
    parameter  int LINES = 4,
    localparam int IDXW  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [1:0]              cpu_op,
    input logic [IDXW-1:0]         cpu_line,
    input logic [1:0]              snp_op,
    input logic [IDXW-1:0]         snp_line,
    input line_state_e [LINES-1:0] line_st,
    input logic [1:0]              bus_cmd,
    input logic                    supply_strobe,
    input logic                    wb_strobe
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_cmd == CMD_NONE && !supply_strobe && !wb_strobe));

    a_r2_read_from_load: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == CMD_READ) |-> ($past(cpu_op) == CPU_LOAD));

    a_r3_store_ends_modified: assert property (@(posedge clk) disable iff (rst)
        (cpu_op == CPU_STORE) |=> (line_st[$past(cpu_line)] == ST_M));

    a_r4_supply_needs_snoop: assert property (@(posedge clk) disable iff (rst)
        supply_strobe |-> ($past(snp_op) != SNP_IDLE));

    a_r6_snoop_kill: assert property (@(posedge clk) disable iff (rst)
        ((snp_op == SNP_READX || snp_op == SNP_UPGRADE) &&
         !(cpu_op != CPU_IDLE && cpu_line == snp_line))
        |=> (line_st[$past(snp_line)] == ST_I));

    a_r7_wb_from_evict: assert property (@(posedge clk) disable iff (rst)
        wb_strobe |-> ($past(cpu_op) == CPU_EVICT));

    a_r7_evict_clears: assert property (@(posedge clk) disable iff (rst)
        (cpu_op == CPU_EVICT) |=> (line_st[$past(cpu_line)] == ST_I));
endmodule

bind moesi_ctrl moesi_ctrl_chk #(.LINES(LINES)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cpu_op        (cpu_op),
    .cpu_line      (cpu_line),
    .snp_op        (snp_op),
    .snp_line      (snp_line),
    .line_st       (line_st_q),
    .bus_cmd       (bus_cmd),
    .supply_strobe (supply_strobe),
    .wb_strobe     (wb_strobe)
);

// File: tb/moesi_ctrl_tb.sv
`timescale 1ns/1ps
module moesi_ctrl_tb_top;
    localparam int LINES = 4;
    localparam int IDXW  = 2;

    localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      cpu_op = 2'd0;
    logic [IDXW-1:0] cpu_line = '0;
    logic            fill_shared = 1'b0;
    logic [1:0]      snp_op = 2'd0;
    logic [IDXW-1:0] snp_line = '0;
    logic [IDXW-1:0] peek_line = '0;
    logic [2:0]      peek_state;
    logic            peek_stale;
    logic [1:0]      bus_cmd;
    logic [IDXW-1:0] bus_cmd_line;
    logic            supply_strobe;
    logic [IDXW-1:0] supply_line;
    logic            wb_strobe;
    logic [IDXW-1:0] wb_line;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int r_cmd, r_cmd_line, r_sup, r_sup_line, r_wb, r_wb_line;

    always #2.5 clk = ~clk;

    moesi_ctrl #(.LINES(LINES)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_op(cpu_op), .cpu_line(cpu_line), .fill_shared(fill_shared),
        .snp_op(snp_op), .snp_line(snp_line),
        .peek_line(peek_line), .peek_state(peek_state), .peek_stale(peek_stale),
        .bus_cmd(bus_cmd), .bus_cmd_line(bus_cmd_line),
        .supply_strobe(supply_strobe), .supply_line(supply_line),
        .wb_strobe(wb_strobe), .wb_line(wb_line)
    );

    // Expected behaviour, from the requirements
    function automatic int exp_snp_state(int st, int op);
        if (op == 1) begin
            if (st == SM) return SO;
            if (st == SE) return SS;
            return st;
        end
        if (op == 2 || op == 3) return SI;
        return st;
    endfunction

    function automatic int exp_snp_supply(int st, int op);
        return (op != 0 && (st == SM || st == SO)) ? 1 : 0;
    endfunction

    function automatic int exp_cpu_state(int st, int op, int fs);
        if (op == 1) return (st == SI) ? (fs != 0 ? SS : SE) : st;
        if (op == 2) return SM;
        if (op == 3) return SI;
        return st;
    endfunction

    function automatic int exp_cpu_cmd(int st, int op);
        if (op == 1 && st == SI) return 1;
        if (op == 2) begin
            if (st == SI) return 2;
            if (st == SS || st == SO) return 3;
        end
        return 0;
    endfunction

    function automatic int exp_cpu_wb(int st, int op);
        return (op == 3 && (st == SM || st == SO)) ? 1 : 0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one request cycle, sample the registered result one cycle later
    task automatic run(int cop, int cl, int fs, int sop, int sl);
        @(negedge clk);
        cpu_op      = 2'(cop);
        cpu_line    = IDXW'(cl);
        fill_shared = fs[0];
        snp_op      = 2'(sop);
        snp_line    = IDXW'(sl);
        @(negedge clk);
        r_cmd      = int'(bus_cmd);
        r_cmd_line = int'(bus_cmd_line);
        r_sup      = int'(supply_strobe);
        r_sup_line = int'(supply_line);
        r_wb       = int'(wb_strobe);
        r_wb_line  = int'(wb_line);
        cpu_op = 2'd0;
        snp_op = 2'd0;
        fill_shared = 1'b0;
    endtask

    task automatic peek(int line, output int st, output int stale);
        peek_line = IDXW'(line);
        #0.5;
        st    = int'(peek_state);
        stale = int'(peek_stale);
    endtask

    task automatic set_state(int line, int st);
        run(3, line, 0, 0, 0);
        case (st)
            SS: run(1, line, 1, 0, 0);
            SE: run(1, line, 0, 0, 0);
            SM: run(2, line, 0, 0, 0);
            SO: begin
                run(2, line, 0, 0, 0);
                run(0, 0, 0, 1, line);
            end
            default: ;
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int st, stale;
        repeat (4) @(negedge clk);
        // R1 during reset
        for (int l = 0; l < LINES; l++) begin
            peek(l, st, stale);
            check("R1", "state in reset", st, SI);
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "cmd after reset", int'(bus_cmd), 0);
        check("R1", "supply after reset", int'(supply_strobe), 0);
        check("R1", "wb after reset", int'(wb_strobe), 0);
        for (int l = 0; l < LINES; l++) begin
            peek(l, st, stale);
            check("R1", "state after reset", st, SI);
        end

        // Every start state against every single operation
        for (int s0 = 0; s0 < 5; s0++) begin
            for (int op = 0; op < 7; op++) begin
                int a, b, cop, fs, sop, es, ecmd, esup, ewb;
                string tag;
                a = (s0 + op) % LINES;
                b = (a + 1) % LINES;
                set_state(b, SM);
                set_state(a, s0);
                cop = 0; fs = 0; sop = 0;
                case (op)
                    0: begin cop = 1; fs = 0; end
                    1: begin cop = 1; fs = 1; end
                    2: cop = 2;
                    3: cop = 3;
                    4: sop = 1;
                    5: sop = 2;
                    default: sop = 3;
                endcase
                if (cop != 0) begin
                    es   = exp_cpu_state(s0, cop, fs);
                    ecmd = exp_cpu_cmd(s0, cop);
                    ewb  = exp_cpu_wb(s0, cop);
                    esup = 0;
                end else begin
                    es   = exp_snp_state(s0, sop);
                    esup = exp_snp_supply(s0, sop);
                    ecmd = 0;
                    ewb  = 0;
                end
                if (op <= 1) tag = "R2";
                else if (op == 2) tag = "R3";
                else if (op == 3) tag = "R7";
                else if (op == 4) tag = (s0 == SM || s0 == SO) ? "R4" : "R5";
                else tag = "R6";
                run(cop, a, fs, sop, a);
                peek(a, st, stale);
                check(tag, "next state", st, es);
                check(tag, "bus cmd", r_cmd, ecmd);
                check(tag, "supply", r_sup, esup);
                check(tag, "write-back", r_wb, ewb);
                check("R8", "stale flag", stale, (es == SM || es == SO) ? 1 : 0);
                if (ecmd != 0) check("R10", "cmd line", r_cmd_line, a);
                if (esup != 0) check("R10", "supply line", r_sup_line, a);
                if (ewb != 0)  check("R10", "wb line", r_wb_line, a);
                peek(b, st, stale);
                check("R11", "neighbour state", st, SM);
                run(0, 0, 0, 0, 0);
                check("R10", "cmd one cycle", r_cmd, 0);
                check("R10", "supply one cycle", r_sup, 0);
                check("R10", "wb one cycle", r_wb, 0);
            end
        end

        // Same line, same cycle: snoop ordered before processor
        for (int s0 = 0; s0 < 5; s0++) begin
            for (int sop = 1; sop < 4; sop++) begin
                for (int cop = 1; cop < 4; cop++) begin
                    int a, mid, es;
                    a = s0 % LINES;
                    set_state(a, s0);
                    mid = exp_snp_state(s0, sop);
                    es  = exp_cpu_state(mid, cop, 0);
                    run(cop, a, 0, sop, a);
                    peek(a, st, stale);
                    check("R9", "collide state", st, es);
                    check("R9", "collide supply", r_sup, exp_snp_supply(s0, sop));
                    check("R9", "collide cmd", r_cmd, exp_cpu_cmd(mid, cop));
                    check("R9", "collide wb", r_wb, exp_cpu_wb(mid, cop));
                end
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule